// File: doc/BRIEF.md
# Serial Receive Queue with Per-Character Error Flags

This block turns an asynchronous serial input into a queue of characters. The line is sampled on a baud tick that runs sixteen times faster than the bit rate. The character format is an input and must match the far-end transmitter: five to eight data bits sent least significant bit first, an optional parity bit of either sense, and one stop bit.

Each completed character is stored in a 64-entry first-in first-out queue. The stored word is the data together with three flags of its own: parity error, framing error and break. Software or a DMA engine drains the queue through a single pop strobe. The head entry is always visible on the read outputs.

The block reports the queue fill level and raises a request when that level reaches a selected threshold. It also keeps a sticky overflow indication for characters it had to drop, and an idle indication when the line has gone quiet while characters are still waiting.

Top module: `uart_rx_queue`

## Requirements
- R1: `cfgDataBits` selects the data width: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Bits are received least significant first. `rdData` holds the character in its low bits, and the unused upper bits read as zero.
- R2: The queue holds 64 entries and returns them in arrival order. `fillLevel` gives the entry count and `rdValid` is high whenever the count is nonzero. A `popReq` pulse removes the head entry in the clock cycle it is sampled. A `popReq` on an empty queue has no effect.
- R3: A falling edge on the line starts a character only if the line is still low eight baud ticks later, at the middle of the start bit. A shorter low pulse queues nothing.
- R4: Parity is controlled by two inputs. With `cfgParEn`=1, one parity bit follows the data. With `cfgParOdd`=0 the parity is even: the data bits plus the parity bit hold an even number of ones. With `cfgParOdd`=1 that count is odd. `rdParErr` is set for a character whose parity bit breaks this rule. With `cfgParEn`=0, `rdParErr` is 0.
- R5: A low level sampled at the middle of the stop bit sets `rdFrmErr` for that character. After such a character the receiver waits for the line to return high before it accepts a new start bit.
- R6: A break is a line held low through every data bit, the parity bit (if enabled) and the stop bit. A break queues exactly one entry: data 0, `rdBrk`=1, `rdFrmErr`=1, `rdParErr`=0. Nothing more is queued while the line stays low.
- R7: A character that completes while the queue is full and no pop is taking place is dropped, and the queue contents are left unchanged. This sets `overflow`, which stays high until the next successful pop.
- R8: `cfgTrig` selects the trigger level: 0 selects 1 entry, 1 selects 16, 2 selects 32 and 3 selects 56. `trigIrq` is high exactly while `fillLevel` is at or above that level.
- R9: `idleFlag` goes high once the receiver has waited four character times with no start bit while the queue holds data. One character time is 16 ticks for each of the start, data, parity and stop bits. The flag clears when a start bit begins or the queue empties.
- R10: After reset the queue is empty, and `trigIrq`, `overflow` and `idleFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxIn | input | 1 | Serial line input, idle high |
| cfgDataBits | input | 2 | Data width select (R1 encoding) |
| cfgParEn | input | 1 | Parity bit present |
| cfgParOdd | input | 1 | Odd parity when 1, even when 0 |
| cfgTrig | input | 2 | Trigger level select (R8 encoding) |
| popReq | input | 1 | Remove the head entry |
| rdData | output | 8 | Head entry data |
| rdParErr | output | 1 | Head entry parity error flag |
| rdFrmErr | output | 1 | Head entry framing error flag |
| rdBrk | output | 1 | Head entry break flag |
| rdValid | output | 1 | Queue not empty |
| fillLevel | output | 7 | Number of queued entries |
| trigIrq | output | 1 | Fill level at or above the trigger level |
| overflow | output | 1 | Sticky dropped-character indication |
| idleFlag | output | 1 | Line idle with data waiting |

## Verification
The bench sends a short low pulse that must not start a character; a receiver that trusts the first edge would queue a spurious entry. It holds the line low for more than two character times and expects a single break entry. A design that fails to wait for the line to go high would fill the queue with zeros, and one that checks only the stop bit would tag the break as a plain framing error. It fills the queue to 65 characters and expects the last one to be lost with the sticky flag raised. A design that overwrites the head or the tail would instead return wrong data when the queue is drained. It also checks the idle flag on both sides of the four-character window and the trigger output at both sides of the level of 56, where a counting error of one shows up.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int MAX_BITS = 8;
  localparam int ENT_W    = MAX_BITS + 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rxState_e;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic clrShift;
    logic shiftBit;
    logic capPar;
    logic push;
  } rxStrobe_t;

  function automatic int trigLevel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int IDLE_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       rxIn,
  input  logic [1:0] cfgDataBits,
  input  logic       cfgParEn,
  input  logic       qEmpty,
  output logic       rxBit,
  output rxStrobe_t  strobe,
  output logic       idleFlag
);
  localparam int CNT_W    = $clog2(OVS);
  localparam int IDLE_MAX = IDLE_CHARS * OVS * (MAX_BITS + 3);
  localparam int IDLE_W   = $clog2(IDLE_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

  rxState_e          state;
  logic [1:0]        rxSync;
  logic [CNT_W-1:0]  tickCnt;
  logic [2:0]        bitIdx;
  logic [2:0]        lastIdx;
  logic [IDLE_W-1:0] idleCnt;
  logic [IDLE_W-1:0] idleLimit;
  logic              atMid;
  logic              atEnd;

  assign rxBit   = rxSync[1];
  assign lastIdx = 3'd4 + {1'b0, cfgDataBits};
  assign atMid   = baudTick && (tickCnt == CNT_MID);
  assign atEnd   = baudTick && (tickCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxIn};
  end

  always_comb begin
    strobe          = '0;
    strobe.clrShift = (state == ST_START) && atMid && !rxBit;
    strobe.shiftBit = (state == ST_DATA)  && atEnd;
    strobe.capPar   = (state == ST_PAR)   && atEnd;
    strobe.push     = (state == ST_STOP)  && atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (baudTick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!rxBit) state <= ST_START;
        end
        ST_START: begin
          if (tickCnt == CNT_MID) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxBit ? ST_IDLE : ST_DATA;
          end else tickCnt <= tickCnt + 1'b1;
        end
        ST_DATA: begin
          if (tickCnt == CNT_LAST) begin
            tickCnt <= '0;
            if (bitIdx == lastIdx) state <= cfgParEn ? ST_PAR : ST_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end else tickCnt <= tickCnt + 1'b1;
        end
        ST_PAR: begin
          if (tickCnt == CNT_LAST) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else tickCnt <= tickCnt + 1'b1;
        end
        ST_STOP: begin
          if (tickCnt == CNT_LAST) begin
            tickCnt <= '0;
            state   <= rxBit ? ST_IDLE : ST_WAITHI;
          end else tickCnt <= tickCnt + 1'b1;
        end
        default: begin
          tickCnt <= '0;
          if (rxBit) state <= ST_IDLE;
        end
      endcase
    end
  end

  // idle window: IDLE_CHARS character times measured in baud ticks
  assign idleLimit = IDLE_W'(IDLE_CHARS * OVS *
                     (7 + int'(cfgDataBits) + int'(cfgParEn)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                idleCnt <= '0;
    else if (state != ST_IDLE || qEmpty)      idleCnt <= '0;
    else if (baudTick && idleCnt < idleLimit) idleCnt <= idleCnt + 1'b1;
  end

  assign idleFlag = (state == ST_IDLE) && !qEmpty && (idleCnt >= idleLimit);

endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxBit,
  input  rxStrobe_t           strobe,
  input  logic [1:0]          cfgDataBits,
  input  logic                cfgParEn,
  input  logic                cfgParOdd,
  input  logic                popReq,
  output logic [MAX_BITS-1:0] rdData,
  output logic                rdParErr,
  output logic                rdFrmErr,
  output logic                rdBrk,
  output logic                qEmpty,
  output logic [FILL_W-1:0]   fillLevel,
  output logic                overflow
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [MAX_BITS-1:0] shiftReg;
  logic [MAX_BITS-1:0] aligned;
  logic                parAcc;
  logic                parBit;
  logic                allZero;
  logic                isFrm;
  logic                isBrk;
  logic                isParErr;
  logic [ENT_W-1:0]    newEntry;
  logic [ENT_W-1:0]    mem [DEPTH];
  logic [ADDR_W-1:0]   wrPtr;
  logic [ADDR_W-1:0]   rdPtr;
  logic                qFull;
  logic                doPush;
  logic                doPop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
      allZero  <= 1'b1;
    end else if (strobe.clrShift) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      parBit   <= 1'b0;
      allZero  <= 1'b1;
    end else if (strobe.shiftBit) begin
      shiftReg <= {rxBit, shiftReg[MAX_BITS-1:1]};
      parAcc   <= parAcc ^ rxBit;
      allZero  <= allZero & ~rxBit;
    end else if (strobe.capPar) begin
      parBit   <= rxBit;
      allZero  <= allZero & ~rxBit;
    end
  end

  // the first data bit sits lowest after the shifts; drop unused positions
  assign aligned  = shiftReg >> (2'd3 - cfgDataBits);
  assign isFrm    = !rxBit;
  assign isBrk    = isFrm && allZero;
  assign isParErr = cfgParEn && !isBrk && (parBit != (parAcc ^ cfgParOdd));
  assign newEntry = {isBrk, isFrm, isParErr, isBrk ? '0 : aligned};

  assign qEmpty = (fillLevel == '0);
  assign qFull  = (fillLevel == FILL_W'(DEPTH));
  assign doPop  = popReq && !qEmpty;
  assign doPush = strobe.push && (!qFull || doPop);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillLevel <= '0;
      overflow  <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == ADDR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == ADDR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      fillLevel <= fillLevel + 1'b1;
      else if (doPop && !doPush) fillLevel <= fillLevel - 1'b1;
      if (strobe.push && !doPush) overflow <= 1'b1;
      else if (doPop)             overflow <= 1'b0;
    end
  end

  assign {rdBrk, rdFrmErr, rdParErr, rdData} = mem[rdPtr];

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int OVS        = 16,
  parameter int IDLE_CHARS = 4,
  parameter int FILL_W     = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick,
  input  logic                rxIn,
  input  logic [1:0]          cfgDataBits,
  input  logic                cfgParEn,
  input  logic                cfgParOdd,
  input  logic [1:0]          cfgTrig,
  input  logic                popReq,
  output logic [MAX_BITS-1:0] rdData,
  output logic                rdParErr,
  output logic                rdFrmErr,
  output logic                rdBrk,
  output logic                rdValid,
  output logic [FILL_W-1:0]   fillLevel,
  output logic                trigIrq,
  output logic                overflow,
  output logic                idleFlag
);
  rxStrobe_t strobe;
  logic      rxBit;
  logic      qEmpty;

  rxq_ctrl #(.OVS(OVS), .IDLE_CHARS(IDLE_CHARS)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxIn),
    .cfgDataBits(cfgDataBits), .cfgParEn(cfgParEn), .qEmpty(qEmpty),
    .rxBit(rxBit), .strobe(strobe), .idleFlag(idleFlag)
  );

  rxq_data #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_data (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .strobe(strobe),
    .cfgDataBits(cfgDataBits), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .popReq(popReq), .rdData(rdData), .rdParErr(rdParErr),
    .rdFrmErr(rdFrmErr), .rdBrk(rdBrk), .qEmpty(qEmpty),
    .fillLevel(fillLevel), .overflow(overflow)
  );

  assign rdValid = !qEmpty;
  assign trigIrq = int'(fillLevel) >= trigLevel(cfgTrig);

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH  = 64,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              popReq,
  input logic [FILL_W-1:0] fillLevel,
  input logic              trigIrq,
  input logic              overflow,
  input logic              idleFlag,
  input logic              rdValid,
  input logic              rdBrk,
  input logic              rdFrmErr,
  input logic              rdParErr,
  input logic [7:0]        rdData
);
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillLevel) <= DEPTH);

  p_fill_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (int'(fillLevel) <= int'($past(fillLevel)) + 1) &&
             (int'(fillLevel) + 1 >= int'($past(fillLevel))));

  p_brk_tag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdBrk) |-> (rdFrmErr && !rdParErr && rdData == 8'h00));

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !popReq) |=> overflow);

  p_irq_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    trigIrq |-> (fillLevel != '0));

  p_idle_nonempty_r9: assert property (@(posedge clk) disable iff (!rstN)
    idleFlag |-> rdValid);
endmodule

bind uart_rx_queue rxq_checker #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rstN(rstN), .popReq(popReq), .fillLevel(fillLevel),
  .trigIrq(trigIrq), .overflow(overflow), .idleFlag(idleFlag),
  .rdValid(rdValid), .rdBrk(rdBrk), .rdFrmErr(rdFrmErr),
  .rdParErr(rdParErr), .rdData(rdData)
);

// File: tb/tb_uart_rx_queue.sv
`timescale 1ns/1ps
module tb_uart_rx_queue;
  localparam int TDIV   = 3;
  localparam int OVS    = 16;
  localparam int BITCLK = OVS * TDIV;

  logic       clk = 1'b0;
  logic       rstN, baudTick, rxIn, cfgParEn, cfgParOdd, popReq;
  logic [1:0] cfgDataBits, cfgTrig;
  logic [7:0] rdData;
  logic       rdParErr, rdFrmErr, rdBrk, rdValid, trigIrq, overflow, idleFlag;
  logic [6:0] fillLevel;

  int  total = 0;
  int  bad   = 0;
  bit  expOvf = 0;
  logic [10:0] mq[$];

  always #2.5 clk = ~clk;

  uart_rx_queue dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxIn(rxIn),
    .cfgDataBits(cfgDataBits), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgTrig(cfgTrig), .popReq(popReq), .rdData(rdData), .rdParErr(rdParErr),
    .rdFrmErr(rdFrmErr), .rdBrk(rdBrk), .rdValid(rdValid),
    .fillLevel(fillLevel), .trigIrq(trigIrq), .overflow(overflow),
    .idleFlag(idleFlag)
  );

  initial begin
    baudTick = 1'b0;
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      baudTick = 1'b1;
      @(negedge clk);
      baudTick = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int lvlOf(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
  endfunction

  function automatic logic [7:0] maskOf(input logic [1:0] s);
    return 8'hFF >> (3 - s);
  endfunction

  function automatic logic parOf(input logic [7:0] d, input logic badPar);
    return (^(d & maskOf(cfgDataBits))) ^ cfgParOdd ^ badPar;
  endfunction

  // expected queue word {brk, frm, parErr, data}
  function automatic logic [10:0] expEntry(input logic [7:0] d, input logic badPar,
                                           input logic stopLow);
    logic [7:0] m;
    logic brk, par;
    m   = d & maskOf(cfgDataBits);
    brk = stopLow && (m == 0) && (!cfgParEn || !parOf(d, badPar));
    par = cfgParEn && badPar && !brk;
    return {brk, stopLow, par, brk ? 8'h00 : m};
  endfunction

  task automatic driveBit(input logic v);
    rxIn = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic sendChar(input logic [7:0] d, input logic badPar, input logic stopLow);
    driveBit(1'b0);
    for (int i = 0; i < 5 + int'(cfgDataBits); i++) driveBit(d[i]);
    if (cfgParEn) driveBit(parOf(d, badPar));
    driveBit(!stopLow);
    driveBit(1'b1);
    if (mq.size() < 64) mq.push_back(expEntry(d, badPar, stopLow));
    else expOvf = 1;
  endtask

  task automatic checkLevel(input string tag);
    chk({tag, " fill"}, 32'(fillLevel), 32'(mq.size()));
    chk("R8 trigIrq", 32'(trigIrq), 32'(mq.size() >= lvlOf(cfgTrig)));
    chk("R7 overflow", 32'(overflow), 32'(expOvf));
  endtask

  task automatic drain(input string tag);
    while (mq.size() > 0) begin
      logic [10:0] e;
      e = mq.pop_front();
      chk({tag, " valid"}, 32'(rdValid), 32'd1);
      chk({tag, " entry"}, 32'({rdBrk, rdFrmErr, rdParErr, rdData}), 32'(e));
      popReq = 1'b1;
      @(negedge clk);
      popReq = 1'b0;
      expOvf = 0;
    end
    chk({tag, " empty"}, 32'(fillLevel), 32'd0);
  endtask

  task automatic charWait(input int n);
    repeat (n * BITCLK * (7 + int'(cfgDataBits) + int'(cfgParEn))) @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; rxIn = 1'b1; popReq = 1'b0;
    cfgDataBits = 2'd3; cfgParEn = 1'b0; cfgParOdd = 1'b0; cfgTrig = 2'd0;
    repeat (8) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 fill", 32'(fillLevel), 0);
    chk("R10 valid", 32'(rdValid), 0);
    chk("R10 trigIrq", 32'(trigIrq), 0);
    chk("R10 overflow", 32'(overflow), 0);
    chk("R10 idle", 32'(idleFlag), 0);

    // R2 pop on empty queue is ignored
    popReq = 1'b1; @(negedge clk); popReq = 1'b0; @(negedge clk);
    chk("R2 pop empty", 32'(fillLevel), 0);

    // R1 narrow formats mask upper bits
    cfgDataBits = 2'd0; sendChar(8'hFF, 0, 0); checkLevel("R1");
    cfgDataBits = 2'd2; sendChar(8'hA5, 0, 0); checkLevel("R1");
    // R4 parity of both senses, good and bad
    cfgDataBits = 2'd3; cfgParEn = 1;
    sendChar(8'h3C, 0, 0); sendChar(8'h3C, 1, 0);
    cfgParOdd = 1; sendChar(8'h81, 0, 0); sendChar(8'h81, 1, 0);
    checkLevel("R4");
    cfgParEn = 0; cfgParOdd = 0;
    // R5 framing error with nonzero data
    sendChar(8'h55, 0, 1); checkLevel("R5");
    // R3 short low pulse rejected
    rxIn = 1'b0; repeat (4 * TDIV) @(negedge clk); rxIn = 1'b1;
    charWait(2); checkLevel("R3");
    // R6 break over more than two character times: one entry only
    rxIn = 1'b0; repeat (25 * BITCLK) @(negedge clk);
    rxIn = 1'b1; repeat (2 * BITCLK) @(negedge clk);
    mq.push_back(11'b110_0000_0000);
    checkLevel("R6");
    drain("R2 R6 order");

    // R9 idle window
    sendChar(8'h42, 0, 0);
    charWait(3);
    chk("R9 idle early", 32'(idleFlag), 0);
    charWait(2);
    chk("R9 idle set", 32'(idleFlag), 1);
    drain("R9");
    chk("R9 idle clear", 32'(idleFlag), 0);

    // R1 R4 R5 R8 random formats and data
    for (int n = 0; n < 40; n++) begin
      cfgDataBits = 2'($urandom_range(0, 3));
      cfgParEn    = 1'($urandom_range(0, 1));
      cfgParOdd   = 1'($urandom_range(0, 1));
      cfgTrig     = 2'($urandom_range(0, 1));
      sendChar(8'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) == 0));
      checkLevel("R1 rand");
      if (mq.size() >= 18) drain("R2 rand");
    end
    drain("R2 rand");

    // R7 R8 fill past the top trigger level and overflow
    cfgDataBits = 2'd3; cfgParEn = 0; cfgTrig = 2'd3;
    for (int n = 0; n < 65; n++) begin
      sendChar(8'(n + 1), 0, 0);
      if (n >= 54) checkLevel("R7 R8 fill");
    end
    chk("R7 full", 32'(fillLevel), 64);
    chk("R7 ovf set", 32'(overflow), 1);
    drain("R7 contents");
    chk("R7 ovf cleared", 32'(overflow), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule